// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one SDRAM read or write burst. A controller pulses `start_i` with the first column, a burst-length code and an ordering choice. From the next clock on, the block presents one column per clock on `col_o` with `valid_o` high, and raises `last_o` on the final beat of a fixed-length burst.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside their aligned block of columns. They use either a wrapping increment or an XOR ordering. A full-page burst walks all 512 columns, wraps from the top column to zero and keeps going until `stop_i` or a new `start_i` arrives. `stop_i` cuts short a burst of any length, and a new start replaces a burst that is still running, so back-to-back commands need no idle clock.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and until the first start, `valid_o` and `last_o` are low and `col_o` is 0.
- R2: A start sampled on a clock edge makes `valid_o` high from that edge on, with `col_o` equal to the sampled start column. One new column follows on every clock while the burst runs.
- R3: In sequential order (`order_i` = 0) with a fixed length BL, beat n has its low log2(BL) bits equal to (start + n) mod BL, and the upper column bits stay the same as in the start column.
- R4: In XOR order (`order_i` = 1) with a fixed length BL, beat n is the start column XOR n.
- R5: Length code `len_i` 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Codes 4 to 7 select a full-page burst.
- R6: `last_o` is high only on beat BL-1 of a fixed-length burst. On the clock after that beat, `valid_o` is low unless a new start was sampled.
- R7: A full-page burst counts up by one modulo 512 from the start column in either order setting. It goes from 511 to 0, never raises `last_o` and never ends by itself.
- R8: When `stop_i` is sampled high during a burst, the beat shown in that cycle is the final one and `valid_o` is low on the next clock. This holds for any length.
- R9: A start sampled while a burst is running begins the new burst at once. When start and stop arrive together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst with the inputs below |
| stop_i | input | 1 | End the running burst after the current beat |
| start_col_i | input | 9 | First column of the burst |
| len_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, else full page) |
| order_i | input | 1 | 0 sequential, 1 XOR ordering |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Every output comes from a register loaded at the edge that samples `start_i`. Beat 0 is therefore due one clock after the start, and beat n is due n clocks later. The effect of a stop or of a final beat shows as `valid_o` low one clock after the edge that samples it. The bench drives inputs on falling edges and checks outputs on the next falling edge, after exactly one rising edge. It then keeps to one check per falling edge for each beat, so each expected value is compared in the cycle it is due.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int COL_W = 9;
    localparam int LEN_W = 3;
    localparam int FIXED_CODES = 4;

    typedef logic [COL_W-1:0] col_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic   active;
        col_t   beat;
        col_t   base;
        len_t   len;
        order_e order;
    } burst_st_t;

    function automatic logic is_full(input len_t len);
        return int'(len) >= FIXED_CODES;
    endfunction

    // Mask covering the column bits that move inside one burst block.
    function automatic col_t len_mask(input len_t len);
        col_t m;
        if (is_full(len)) begin
            m = '1;
        end else begin
            m = col_t'((1 << len) - 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
(
    input  col_t   base,
    input  col_t   beat,
    input  len_t   len,
    input  order_e order,
    output col_t   col
);

    col_t m;
    col_t sum;

    always_comb begin
        m   = len_mask(len);
        sum = base + beat;
        if (order == ORD_XOR && !is_full(len)) begin
            col = base ^ (beat & m);
        end else begin
            col = (base & ~m) | (sum & m);
        end
    end

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      stop,
    input  col_t      start_col,
    input  len_t      len_in,
    input  order_e    order_in,
    output burst_st_t st,
    output logic      last
);

    always_comb begin
        last = st.active && !is_full(st.len) && (st.beat == len_mask(st.len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.active <= 1'b1;
            st.beat   <= '0;
            st.base   <= start_col;
            st.len    <= len_in;
            st.order  <= order_in;
        end else if (st.active) begin
            if (stop || last) begin
                st.active <= 1'b0;
            end else begin
                st.beat <= st.beat + 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    burst_st_t st;
    logic      last;
    col_t      col;
    len_t      held_len;
    logic      held_xor;

    bcs_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .stop      (stop_i),
        .start_col (start_col_i),
        .len_in    (len_i),
        .order_in  (order_e'(order_i)),
        .st        (st),
        .last      (last)
    );

    bcs_col_gen gen_i (
        .base  (st.base),
        .beat  (st.beat),
        .len   (st.len),
        .order (st.order),
        .col   (col)
    );

    assign held_len = st.len;
    assign held_xor = (st.order == ORD_XOR);
    assign col_o    = col;
    assign valid_o  = st.active;
    assign last_o   = last;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
    import bcs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic [LEN_W-1:0] held_len,
    input logic             held_xor
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid_o && !last_o && col_o == '0));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R6
    last_end_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    // R8
    stop_end_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    // R7
    full_no_last_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && is_full(held_len)) |-> !last_o);

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !stop_i && !start_i && (!held_xor || is_full(held_len)))
        |=> (valid_o && col_o == (($past(col_o) & ~len_mask(held_len))
                                 | (col_t'($past(col_o) + 1'b1) & len_mask(held_len)))));

endmodule

bind burst_col_seq burst_col_seq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .held_len    (held_len),
    .held_xor    (held_xor)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_i = '0;
    logic       order_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    burst_col_seq dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .len_i       (len_i),
        .order_i     (order_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    function automatic int blen(input int code);
        return (code > 3) ? 512 : (1 << code);
    endfunction

    function automatic int exp_col(input int base, input int n, input int code, input int xo);
        int bl;
        int blk;
        bl = blen(code);
        if (xo != 0 && bl < 512) return base ^ n;
        blk = base - (base % bl);
        return blk + ((base % bl) + n) % bl;
    endfunction

    task automatic chk(input logic ok, input string req, input string what, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic pulse_start(input int base, input int code, input int xo);
        @(negedge clk);
        start_i = 1'b1;
        start_col_i = 9'(base);
        len_i = 3'(code);
        order_i = xo[0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Runs one burst; stop_at < 0 means no stop request.
    task automatic run_burst(input int base, input int code, input int xo,
                             input int stop_at, input string req);
        int bl;
        int nb;
        bl = blen(code);
        nb = (stop_at >= 0) ? stop_at + 1 : bl;
        pulse_start(base, code, xo);
        for (int i = 0; i < nb; i++) begin
            chk(valid_o == 1'b1, "R2", "valid during beat", int'(valid_o), 1);
            chk(col_o == 9'(exp_col(base, i, code, xo)), req, "column", int'(col_o),
                exp_col(base, i, code, xo));
            chk(last_o == (bl < 512 && i == bl - 1), "R6", "last flag", int'(last_o),
                int'(bl < 512 && i == bl - 1));
            stop_i = (i == stop_at);
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk(valid_o == 1'b0, (stop_at >= 0) ? "R8" : "R6", "valid after end", int'(valid_o), 0);
        chk(last_o == 1'b0, "R6", "last after end", int'(last_o), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(valid_o == 1'b0, "R1", "valid after reset", int'(valid_o), 0);
        chk(last_o == 1'b0, "R1", "last after reset", int'(last_o), 0);
        chk(col_o == 9'd0, "R1", "col after reset", int'(col_o), 0);
    endtask

    task automatic t_sequential();
        run_burst(37, 0, 0, -1, "R5");
        run_burst(5, 1, 0, -1, "R3");
        run_burst(6, 2, 0, -1, "R3");
        run_burst(9'h1FD, 3, 0, -1, "R3");
    endtask

    task automatic t_xor();
        run_burst(2, 2, 1, -1, "R4");
        run_burst(9'h0AD, 3, 1, -1, "R4");
        run_burst(1, 1, 1, -1, "R4");
    endtask

    task automatic t_full_page();
        run_burst(508, 5, 1, 9, "R7");
        run_burst(0, 7, 0, 516, "R7");
        run_burst(300, 4, 0, 2, "R5");
    endtask

    task automatic t_stop();
        run_burst(40, 3, 0, 2, "R8");
        run_burst(12, 2, 1, 0, "R8");
    endtask

    task automatic t_restart();
        pulse_start(16, 3, 0);
        for (int i = 0; i < 3; i++) begin
            chk(col_o == 9'(16 + i), "R9", "first burst column", int'(col_o), 16 + i);
            @(negedge clk);
        end
        start_i = 1'b1;
        stop_i = 1'b1;
        start_col_i = 9'd102;
        len_i = 3'd2;
        order_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(valid_o == 1'b1, "R9", "valid after restart", int'(valid_o), 1);
            chk(col_o == 9'(exp_col(102, i, 2, 0)), "R9", "restart column", int'(col_o),
                exp_col(102, i, 2, 0));
            chk(last_o == (i == 3), "R9", "restart last", int'(last_o), int'(i == 3));
            @(negedge clk);
        end
        chk(valid_o == 1'b0, "R9", "valid after restarted burst", int'(valid_o), 0);
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_xor();
        t_full_page();
        t_stop();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (R1..R9 run): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule